// File: doc/BRIEF.md
# DRAM Parallel Test-Mode Compressor

This block sits between the strobe-and-data pins of a 4-bit-wide DRAM and a 32-bit internal array port. In normal operation it passes single 4-bit accesses through: the three low column bits select one of eight 4-bit groups of the array word. It also watches the strobes for a column-before-row refresh with write enable held low. That cycle latches a test-mode flag. The flag stays set until a row-only refresh or an ordinary column-before-row refresh clears it.

While the flag is set, the low column bits have no effect. A write puts each data pin's value into all eight of that pin's array bits at once, so 32 bits are stored in parallel. A read returns a compressed result: each pin is high when its eight bits agree and low when they differ. Test-mode reads take one more clock cycle to become valid than normal reads, because the array access is slower.

Strobes and write enable are synchronous active-low inputs, sampled on each rising clock edge. Edges are found by comparing each sample with the one taken a cycle earlier. Array bit `g*4+p` holds pin `p` of group `g`.

Top module: `dtm_compressor`

## Requirements
- R1: During reset and after it, `tmode` is 0, `arr_we` is 0, `dq_valid` is 0 and `dq_out` is 0.
- R2: If `ras_n` falls while `cas_n` is low and `we_n` is low, `tmode` is 1 from the next cycle on.
- R3: If `ras_n` falls while `cas_n` is low and `we_n` is high, `tmode` is 0 from the next cycle on.
- R4: A row cycle in which `ras_n` rises again without `cas_n` falling clears `tmode`.
- R5: Row cycles that contain a column access, whether read or write, leave `tmode` unchanged.
- R6: A normal write is a `cas_n` fall with `we_n` low inside a row cycle. In the cycle after the fall edge, `arr_we` pulses for one cycle. `arr_wmask` is 0xF shifted left by 4 times `col`, and `arr_wdata` carries `dq_in` copied into all eight groups.
- R7: A test-mode write pulses `arr_we` with `arr_wmask` all ones. Pin p's value lands in bits g*4+p for g = 0..7, and `col` has no effect.
- R8: In a normal read, `dq_valid` rises NORM_LAT clock edges after the `cas_n` fall edge, and `dq_out` equals `arr_rdata[col*4 +: 4]`.
- R9: In a test read, `dq_out[p]` is 1 when all eight bits g*4+p are equal and 0 otherwise, and `col` has no effect.
- R10: A test read becomes valid NORM_LAT+TEST_XTRA edges after the `cas_n` fall, and is not valid after only NORM_LAT edges.
- R11: `dq_valid` drops on the first edge at which `cas_n` is sampled high. `dq_out` is 0 whenever `dq_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| col | input | 3 | Low column address bits (group select) |
| dq_in | input | 4 | Write data from the pins |
| dq_out | output | 4 | Read data or per-pin compare result |
| dq_valid | output | 1 | Read data valid |
| tmode | output | 1 | Latched test-mode flag |
| arr_we | output | 1 | Array write pulse |
| arr_wmask | output | 32 | Array bit write mask |
| arr_wdata | output | 32 | Array write data |
| arr_rdata | input | 32 | Array read data |

## Verification
A wrong mode flag shows at the ports in three ways, all within one cycle after the strobe sequence: `tmode` itself, the next write's mask (one group instead of all ones), and the next read's data (a raw group instead of the compare result). A wrong captured group or a bad mask shows up when that data is read back later through another path: a group read after a test write, or a compare read after scattered normal writes. A latency counter that is off by one shows up as `dq_valid` being high or low in the exact cycle the bench samples it.

// File: rtl/dtm_pkg.sv
package dtm_pkg;
  localparam int NPIN  = 4;
  localparam int NCOPY = 8;
  localparam int ARR_W = NPIN * NCOPY;
  localparam int SEL_W = $clog2(NCOPY);
endpackage

// File: rtl/dtm_mode_ctrl.sv
module dtm_mode_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output logic tmode,
  output logic acc_go,
  output logic acc_wr
);
  logic ras_q, cas_q, row_q, seen_q, tm_q;
  logic row_d, seen_d, tm_d;
  logic ras_fall, ras_rise, cas_fall;

  assign ras_fall = ras_q & ~ras_n;
  assign ras_rise = ~ras_q & ras_n;
  assign cas_fall = cas_q & ~cas_n;
  assign acc_go   = cas_fall & row_q & ~ras_n;
  assign acc_wr   = ~we_n;
  assign tmode    = tm_q;

  always_comb begin
    row_d  = row_q;
    seen_d = seen_q;
    tm_d   = tm_q;
    if (ras_fall) begin
      if (!cas_n) begin
        tm_d  = ~we_n;
        row_d = 1'b0;
      end else begin
        row_d  = 1'b1;
        seen_d = 1'b0;
      end
    end else if (ras_rise) begin
      if (row_q && !seen_q) tm_d = 1'b0;
      row_d = 1'b0;
    end
    if (acc_go) seen_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q  <= 1'b1;
      cas_q  <= 1'b1;
      row_q  <= 1'b0;
      seen_q <= 1'b0;
      tm_q   <= 1'b0;
    end else begin
      ras_q  <= ras_n;
      cas_q  <= cas_n;
      row_q  <= row_d;
      seen_q <= seen_d;
      tm_q   <= tm_d;
    end
  end
endmodule

// File: rtl/dtm_rd_timer.sv
module dtm_rd_timer #(
  parameter int NORM_LAT  = 2,
  parameter int TEST_XTRA = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_go,
  input  logic tmode,
  input  logic cas_n,
  output logic valid
);
  localparam int MAX_LAT = NORM_LAT + TEST_XTRA;
  localparam int CNT_W   = $clog2(MAX_LAT + 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, lat_q, lat_d;
  logic             cnt_en;

  assign cnt_en = busy_q && (cnt_q < lat_q);
  assign valid  = busy_q && (cnt_q >= lat_q);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    lat_d  = lat_q;
    if (rd_go) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(1);
      lat_d  = tmode ? CNT_W'(MAX_LAT) : CNT_W'(NORM_LAT);
    end else if (cas_n) begin
      busy_d = 1'b0;
    end else if (cnt_en) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      lat_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      lat_q  <= lat_d;
    end
  end
endmodule

// File: rtl/dtm_datapath.sv
module dtm_datapath
  import dtm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_go,
  input  logic             acc_wr,
  input  logic             tmode,
  input  logic [SEL_W-1:0] col,
  input  logic [NPIN-1:0]  dq_in,
  input  logic [ARR_W-1:0] arr_rdata,
  input  logic             valid,
  output logic             arr_we,
  output logic [ARR_W-1:0] arr_wmask,
  output logic [ARR_W-1:0] arr_wdata,
  output logic [NPIN-1:0]  dq_out
);
  logic             we_q, tacc_q;
  logic [SEL_W-1:0] grp_q;
  logic [ARR_W-1:0] mask_q, data_q, mask_d;
  logic [NPIN-1:0]  cmp, sel;

  always_comb begin
    mask_d = '0;
    if (tmode) mask_d = '1;
    else       mask_d[col*NPIN +: NPIN] = '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q   <= 1'b0;
      tacc_q <= 1'b0;
      grp_q  <= '0;
      mask_q <= '0;
      data_q <= '0;
    end else begin
      we_q <= acc_go & acc_wr;
      if (acc_go) begin
        tacc_q <= tmode;
        grp_q  <= col;
        mask_q <= mask_d;
        data_q <= {NCOPY{dq_in}};
      end
    end
  end

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic [NCOPY-1:0] bits;
    for (genvar g = 0; g < NCOPY; g++) begin : g_cp
      assign bits[g] = arr_rdata[g*NPIN + p];
    end
    assign cmp[p] = (&bits) | ~(|bits);
  end

  assign sel       = arr_rdata[grp_q*NPIN +: NPIN];
  assign dq_out    = valid ? (tacc_q ? cmp : sel) : '0;
  assign arr_we    = we_q;
  assign arr_wmask = we_q ? mask_q : '0;
  assign arr_wdata = data_q;
endmodule

// File: rtl/dtm_compressor.sv
module dtm_compressor
  import dtm_pkg::*;
#(
  parameter int NORM_LAT  = 2,
  parameter int TEST_XTRA = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic [SEL_W-1:0] col,
  input  logic [NPIN-1:0]  dq_in,
  output logic [NPIN-1:0]  dq_out,
  output logic             dq_valid,
  output logic             tmode,
  output logic             arr_we,
  output logic [ARR_W-1:0] arr_wmask,
  output logic [ARR_W-1:0] arr_wdata,
  input  logic [ARR_W-1:0] arr_rdata
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       acc_go, acc_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  dtm_mode_ctrl u_mode (
    .clk(clk), .rst_n(rst_int_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .tmode(tmode), .acc_go(acc_go), .acc_wr(acc_wr)
  );

  dtm_rd_timer #(.NORM_LAT(NORM_LAT), .TEST_XTRA(TEST_XTRA)) u_tmr (
    .clk(clk), .rst_n(rst_int_n), .rd_go(acc_go & ~acc_wr), .tmode(tmode),
    .cas_n(cas_n), .valid(dq_valid)
  );

  dtm_datapath u_dp (
    .clk(clk), .rst_n(rst_int_n), .acc_go(acc_go), .acc_wr(acc_wr),
    .tmode(tmode), .col(col), .dq_in(dq_in), .arr_rdata(arr_rdata),
    .valid(dq_valid), .arr_we(arr_we), .arr_wmask(arr_wmask),
    .arr_wdata(arr_wdata), .dq_out(dq_out)
  );
endmodule

// File: rtl/dtm_compressor_chk.sv
module dtm_compressor_chk
  import dtm_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic [NPIN-1:0]  dq_out,
  input logic             dq_valid,
  input logic             tmode,
  input logic             arr_we,
  input logic [ARR_W-1:0] arr_wmask
);
  a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |-> !tmode && !arr_we && !dq_valid);
  a_r2_enter: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n && !we_n && $past(rst_n)) |=> tmode);
  a_r3_exit_cbr: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n && we_n && $past(rst_n)) |=> !tmode);
  a_r6_one_pulse: assert property (@(posedge clk) disable iff (!rst_n) arr_we |=> !arr_we);
  a_r6_norm_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && !tmode) |-> $countones(arr_wmask) == NPIN);
  a_r7_test_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && tmode) |-> (&arr_wmask));
  a_r11_drop: assert property (@(posedge clk) disable iff (!rst_n) cas_n |=> !dq_valid);
  a_r11_zero: assert property (@(posedge clk) disable iff (!rst_n) !dq_valid |-> dq_out == '0);
endmodule

bind dtm_compressor dtm_compressor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .dq_out(dq_out), .dq_valid(dq_valid), .tmode(tmode), .arr_we(arr_we),
  .arr_wmask(arr_wmask)
);

// File: tb/dtm_compressor_tb.sv
module dtm_compressor_tb;
  localparam int NL = 2;
  localparam int TX = 1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ras_n, cas_n, we_n;
  logic [2:0]  col;
  logic [3:0]  dq_in, dq_out;
  logic        dq_valid, tmode, arr_we;
  logic [31:0] arr_wmask, arr_wdata, mem;
  int          total = 0, fails = 0;
  bit          exp_tm = 1'b0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  dtm_compressor #(.NORM_LAT(NL), .TEST_XTRA(TX)) u_dut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .col(col), .dq_in(dq_in), .dq_out(dq_out), .dq_valid(dq_valid),
    .tmode(tmode), .arr_we(arr_we), .arr_wmask(arr_wmask),
    .arr_wdata(arr_wdata), .arr_rdata(mem)
  );

  always @(posedge clk) if (arr_we) mem <= (mem & ~arr_wmask) | (arr_wdata & arr_wmask);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] f_cmp(input logic [31:0] m);
    logic [3:0] r;
    for (int p = 0; p < 4; p++) begin
      logic [7:0] b;
      for (int g = 0; g < 8; g++) b[g] = m[g*4+p];
      r[p] = (b == 8'h00) || (b == 8'hFF);
    end
    return r;
  endfunction

  task automatic tick(); @(negedge clk); endtask

  task automatic cbr(input bit we);
    cas_n = 1'b0; tick();
    ras_n = 1'b0; we_n = we; tick();
    exp_tm = ~we;
    chk(tmode == exp_tm, we ? "R3" : "R2", tmode, exp_tm);
    ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; tick(); tick();
  endtask

  task automatic row_only();
    ras_n = 1'b0; tick(); tick();
    ras_n = 1'b1; tick();
    exp_tm = 1'b0;
    chk(tmode == 1'b0, "R4", tmode, 0);
    tick();
  endtask

  task automatic wr(input logic [2:0] c, input logic [3:0] d);
    logic [31:0] em;
    ras_n = 1'b0; tick();
    cas_n = 1'b0; we_n = 1'b0; col = c; dq_in = d; tick();
    em = exp_tm ? 32'hFFFF_FFFF : (32'hF << (c*4));
    chk(arr_we == 1'b1, exp_tm ? "R7" : "R6", arr_we, 1);
    chk(arr_wmask == em, exp_tm ? "R7" : "R6", arr_wmask, em);
    chk((arr_wdata & em) == ({8{d}} & em), exp_tm ? "R7" : "R6", arr_wdata & em, {8{d}} & em);
    tick();
    chk(arr_we == 1'b0, "R6", arr_we, 0);
    cas_n = 1'b1; we_n = 1'b1; tick();
    ras_n = 1'b1; tick(); tick();
    chk(tmode == exp_tm, "R5", tmode, exp_tm);
  endtask

  task automatic rd(input logic [2:0] c);
    logic [3:0] e;
    int lat;
    lat = exp_tm ? NL + TX : NL;
    ras_n = 1'b0; tick();
    cas_n = 1'b0; col = c; tick();
    for (int k = 1; k < lat; k++) begin
      chk(dq_valid == 1'b0, exp_tm ? "R10" : "R8", dq_valid, 0);
      chk(dq_out == 4'h0, "R11", dq_out, 0);
      col = ~c;
      tick();
    end
    e = exp_tm ? f_cmp(mem) : mem[c*4 +: 4];
    chk(dq_valid == 1'b1, exp_tm ? "R10" : "R8", dq_valid, 1);
    chk(dq_out == e, exp_tm ? "R9" : "R8", dq_out, e);
    cas_n = 1'b1; tick();
    chk(dq_valid == 1'b0, "R11", dq_valid, 0);
    chk(dq_out == 4'h0, "R11", dq_out, 0);
    ras_n = 1'b1; tick(); tick();
    chk(tmode == exp_tm, "R5", tmode, exp_tm);
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
    col = '0; dq_in = '0; mem = '0;
    repeat (3) tick();
    chk(tmode == 0 && arr_we == 0 && dq_valid == 0 && dq_out == 0, "R1",
        {tmode, arr_we, dq_valid, dq_out}, 0);
    rst_n = 1'b1;
    repeat (4) tick();
    chk(tmode == 0 && dq_valid == 0, "R1", {tmode, dq_valid}, 0);
    // directed: normal group write/read
    wr(3'd5, 4'hA); rd(3'd5); rd(3'd0);
    // enter, test write all-equal, then break one group
    cbr(1'b0);
    wr(3'd2, 4'h6); rd(3'd7);
    cbr(1'b1);
    wr(3'd3, 4'h3); rd(3'd3);
    cbr(1'b0);
    rd(3'd1);
    row_only();
    rd(3'd6);
    cbr(1'b0); cbr(1'b0);
    // random mix
    for (int i = 0; i < 60; i++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 4)       wr(3'($urandom), 4'($urandom));
      else if (op < 8)  rd(3'($urandom));
      else if (op == 8) cbr(1'($urandom));
      else              row_only();
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule